// File: doc/BRIEF.md
# Windowed Pixel Readout Sequencer

This block walks a rectangular window of a square pixel array in progressive scan order: every column pair of one row, then the next row pair, until the window is exhausted. Columns and rows are addressed in pairs, so every address the block issues is even. Four configuration registers, written through a plain register-write port, hold the window origin and its extent in each direction. The pending values are copied into the working window only when a new frame is started. Writes made during a scan therefore never disturb the frame in flight.

Each column pair occupies two clock cycles. The two internal readout buses, A and B, carry the two pixels of the current pair. In single-stream mode they are interleaved onto stream 0, which gives one pixel per cycle. In dual-stream mode bus A goes to stream 0 and bus B to stream 1. Both streams are then valid together, once per pair, at half the single-stream rate. The block flags the last column pair, the last cycle of each row and the last cycle of the frame.

Top module: `pixwin_seq`

## Requirements
- R1: After reset the block is idle: `scanning`, `out0_valid`, `out1_valid`, `row_end` and `frame_done` are all low.
- R2: The lowest bit of a written start value is ignored. The first address of a frame is the pending start value with bit 0 cleared.
- R3: While scanning, the column address begins at the column start. It stays on each column pair for two cycles and then advances by 2. After the last column pair of a row it returns to the column start, and the row address advances by 2.
- R4: The last column equals start + size − 2, and the same holds for rows. Bit 0 of a size is ignored, and a size below 2 counts as one pair. A result above COLS−2 (or ROWS−2) is clamped to that value.
- R5: In single-stream mode (`dual_mode`=0, sampled at frame start), `out0_data` carries bus A in the first cycle of each pair and bus B in the second. `out0_valid` is high in both cycles and `out1_valid` stays low.
- R6: In dual-stream mode (`dual_mode`=1), `out0_data` carries bus A and `out1_data` carries bus B. Both valid flags are high only in the first cycle of each pair.
- R7: `col_eos` is high while the column address equals the last column. `row_end` is high only in the second cycle of the last column pair of each row.
- R8: `frame_done` is a single-cycle pulse in the final cycle of the frame, which is the last cycle of the last row. `scanning` is low in the following cycle.
- R9: Configuration writes made while scanning do not change the frame in progress. They take effect at the next frame start.
- R10: A configuration write in the same cycle as an accepted `frame_start` lands in the pending registers for the following frame. The frame being started uses the earlier values.
- R11: `frame_start` is ignored while a frame is being scanned.
- R12: Register select encoding: 0 = column start, 1 = row start, 2 = column size, 3 = row size. Reset values are start 0 and full-array size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (R12) |
| cfg_wdata | input | REG_W | Configuration write value |
| frame_start | input | 1 | Starts a frame when idle |
| dual_mode | input | 1 | 1 = two streams, 0 = one interleaved stream |
| bus_a | input | PIX_W | Internal readout bus A (first pixel of pair) |
| bus_b | input | PIX_W | Internal readout bus B (second pixel of pair) |
| scanning | output | 1 | A frame is being scanned |
| col_addr | output | CW | Current column pair address (even) |
| row_addr | output | RW | Current row pair address (even) |
| col_eos | output | 1 | Column address is at the window's last column |
| row_eos | output | 1 | Row address is at the window's last row |
| row_end | output | 1 | Final cycle of a row |
| frame_done | output | 1 | Final cycle of the frame |
| out0_data | output | PIX_W | Stream 0 pixel |
| out0_valid | output | 1 | Stream 0 valid |
| out1_data | output | PIX_W | Stream 1 pixel |
| out1_valid | output | 1 | Stream 1 valid |

## Verification
The collision that matters most is a configuration write landing on the same edge that accepts a frame start. Here the pending register and the working window are both clocked at once. The bench drives a column-start write together with `frame_start`, then compares the addresses of that frame against the older value. It then checks that the next frame opens at the newly written value. A further case issues a write and a repeated `frame_start` in the middle of a scan, and requires every address of that frame to follow the unchanged window.

// File: rtl/pixwin_pkg.sv
package pixwin_pkg;

    typedef enum logic [1:0] {
        SEL_COL_START = 2'd0,
        SEL_ROW_START = 2'd1,
        SEL_COL_SIZE  = 2'd2,
        SEL_ROW_SIZE  = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } seq_state_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } pair_phase_e;

    // Clears bit 0 so that positions and extents stay on pair boundaries.
    function automatic int unsigned even_floor(input int unsigned v);
        return v & 32'hFFFF_FFFE;
    endfunction

    // Final pair position of a window axis, clamped to the array edge.
    function automatic int unsigned window_last(input int unsigned first,
                                                input int unsigned extent,
                                                input int unsigned edge_pos);
        int unsigned span;
        int unsigned last;
        span = even_floor(extent);
        if (span < 2) span = 2;
        last = even_floor(first) + span - 2;
        if (last > edge_pos) last = edge_pos;
        return last;
    endfunction

endpackage

// File: rtl/pixwin_cfg.sv
module pixwin_cfg
    import pixwin_pkg::*;
#(
    parameter int COLS  = 2048,
    parameter int ROWS  = 2048,
    parameter int REG_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  cfg_sel_e                 wr_sel,
    input  logic [REG_W-1:0]         wr_data,
    input  logic                     commit,
    output logic [$clog2(COLS)-1:0]  col_first_nxt,
    output logic [$clog2(ROWS)-1:0]  row_first_nxt,
    output logic [$clog2(COLS)-1:0]  col_first,
    output logic [$clog2(COLS)-1:0]  col_last,
    output logic [$clog2(ROWS)-1:0]  row_first,
    output logic [$clog2(ROWS)-1:0]  row_last
);
    localparam int CW = $clog2(COLS);
    localparam int RW = $clog2(ROWS);

    logic [REG_W-1:0] pend_q [4];
    logic [CW-1:0]    col_last_nxt;
    logic [RW-1:0]    row_last_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q[SEL_COL_START] <= '0;
            pend_q[SEL_ROW_START] <= '0;
            pend_q[SEL_COL_SIZE]  <= REG_W'(COLS);
            pend_q[SEL_ROW_SIZE]  <= REG_W'(ROWS);
        end else if (wr_en) begin
            pend_q[wr_sel] <= wr_data;
        end
    end

    always_comb begin
        col_first_nxt = CW'(even_floor(32'(pend_q[SEL_COL_START])));
        row_first_nxt = RW'(even_floor(32'(pend_q[SEL_ROW_START])));
        col_last_nxt  = CW'(window_last(32'(col_first_nxt), 32'(pend_q[SEL_COL_SIZE]), 32'(COLS - 2)));
        row_last_nxt  = RW'(window_last(32'(row_first_nxt), 32'(pend_q[SEL_ROW_SIZE]), 32'(ROWS - 2)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_first <= '0;
            row_first <= '0;
            col_last  <= CW'(COLS - 2);
            row_last  <= RW'(ROWS - 2);
        end else if (commit) begin
            col_first <= col_first_nxt;
            row_first <= row_first_nxt;
            col_last  <= col_last_nxt;
            row_last  <= row_last_nxt;
        end
    end

    AST_LAST_WITHIN_ARRAY: assert property (@(posedge clk) disable iff (rst)
        (32'(col_last) <= 32'(COLS - 2)) && (32'(row_last) <= 32'(ROWS - 2))); // R4

    AST_LAST_NOT_BELOW_FIRST: assert property (@(posedge clk) disable iff (rst)
        (col_last >= col_first) && (row_last >= row_first)); // R4

endmodule

// File: rtl/pixwin_axis.sv
module pixwin_axis #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic [W-1:0] first,
    input  logic [W-1:0] last,
    output logic [W-1:0] addr,
    output logic         at_last
);
    assign at_last = (addr == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            if (at_last) addr <= first;
            else         addr <= addr + W'(2);
        end
    end

    AST_STEP_BY_PAIR: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !at_last) |=> (addr == $past(addr) + W'(2))); // R3

    AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (rst)
        (step && !load && at_last) |=> (addr == $past(first))); // R3

    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (rst)
        (load && !load_val[0]) |=> !addr[0]); // R2

endmodule

// File: rtl/pixwin_outmux.sv
module pixwin_outmux
    import pixwin_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scanning,
    input  logic             dual,
    input  pair_phase_e      phase,
    input  logic [PIX_W-1:0] bus_a,
    input  logic [PIX_W-1:0] bus_b,
    output logic [PIX_W-1:0] out0_data,
    output logic             out0_valid,
    output logic [PIX_W-1:0] out1_data,
    output logic             out1_valid
);
    always_comb begin
        out0_valid = scanning && (!dual || phase == PH_FIRST);
        out1_valid = scanning && dual && phase == PH_FIRST;
        out0_data  = (!dual && phase == PH_SECOND) ? bus_b : bus_a;
        out1_data  = dual ? bus_b : '0;
    end

    AST_SINGLE_NO_STREAM1: assert property (@(posedge clk) disable iff (rst)
        !dual |-> !out1_valid); // R5

    AST_DUAL_ONCE_PER_PAIR: assert property (@(posedge clk) disable iff (rst)
        out1_valid |=> !out1_valid); // R6

    AST_DUAL_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
        out1_valid |-> out0_valid); // R6

endmodule

// File: rtl/pixwin_seq.sv
module pixwin_seq
    import pixwin_pkg::*;
#(
    parameter int COLS  = 2048,
    parameter int ROWS  = 2048,
    parameter int PIX_W = 10,
    parameter int CW    = $clog2(COLS),
    parameter int RW    = $clog2(ROWS),
    parameter int REG_W = ((CW > RW) ? CW : RW) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             frame_start,
    input  logic             dual_mode,
    input  logic [PIX_W-1:0] bus_a,
    input  logic [PIX_W-1:0] bus_b,
    output logic             scanning,
    output logic [CW-1:0]    col_addr,
    output logic [RW-1:0]    row_addr,
    output logic             col_eos,
    output logic             row_eos,
    output logic             row_end,
    output logic             frame_done,
    output logic [PIX_W-1:0] out0_data,
    output logic             out0_valid,
    output logic [PIX_W-1:0] out1_data,
    output logic             out1_valid
);
    seq_state_e  state_q;
    pair_phase_e phase_q;
    logic        dual_q;
    logic        start_ok;
    logic        col_step;
    logic        col_at_last;
    logic        row_at_last;

    logic [CW-1:0] col_first_nxt, col_first, col_last;
    logic [RW-1:0] row_first_nxt, row_first, row_last;

    assign scanning = (state_q == ST_SCAN);
    assign start_ok = frame_start && (state_q == ST_IDLE);
    assign col_step = scanning && (phase_q == PH_SECOND);
    assign col_eos  = scanning && col_at_last;
    assign row_eos  = scanning && row_at_last;
    assign row_end  = col_step && col_at_last;
    assign frame_done = row_end && row_at_last;

    pixwin_cfg #(
        .COLS  (COLS),
        .ROWS  (ROWS),
        .REG_W (REG_W)
    ) u_cfg (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (cfg_we),
        .wr_sel        (cfg_sel_e'(cfg_sel)),
        .wr_data       (cfg_wdata),
        .commit        (start_ok),
        .col_first_nxt (col_first_nxt),
        .row_first_nxt (row_first_nxt),
        .col_first     (col_first),
        .col_last      (col_last),
        .row_first     (row_first),
        .row_last      (row_last)
    );

    pixwin_axis #(.W(CW)) u_col (
        .clk      (clk),
        .rst      (rst),
        .load     (start_ok),
        .load_val (col_first_nxt),
        .step     (col_step),
        .first    (col_first),
        .last     (col_last),
        .addr     (col_addr),
        .at_last  (col_at_last)
    );

    pixwin_axis #(.W(RW)) u_row (
        .clk      (clk),
        .rst      (rst),
        .load     (start_ok),
        .load_val (row_first_nxt),
        .step     (row_end),
        .first    (row_first),
        .last     (row_last),
        .addr     (row_addr),
        .at_last  (row_at_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= PH_FIRST;
            dual_q  <= 1'b0;
        end else if (start_ok) begin
            state_q <= ST_SCAN;
            phase_q <= PH_FIRST;
            dual_q  <= dual_mode;
        end else if (scanning) begin
            phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
            if (frame_done) state_q <= ST_IDLE;
        end
    end

    pixwin_outmux #(.PIX_W(PIX_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .scanning   (scanning),
        .dual       (dual_q),
        .phase      (phase_q),
        .bus_a      (bus_a),
        .bus_b      (bus_b),
        .out0_data  (out0_data),
        .out0_valid (out0_valid),
        .out1_data  (out1_data),
        .out1_valid (out1_valid)
    );

    AST_FRAME_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (!frame_done && !scanning)); // R8

    AST_ROW_END_AT_COL_EOS: assert property (@(posedge clk) disable iff (rst)
        row_end |-> col_eos); // R7

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (scanning && frame_start && !col_step) |=> $stable(col_addr) && $stable(row_addr)); // R11

    AST_WINDOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (scanning && cfg_we) |=> ($stable(col_last) && $stable(row_last) && $stable(col_first))); // R9

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !scanning |-> (!out0_valid && !out1_valid && !row_end)); // R1

endmodule

// File: tb/pixwin_seq_bench.sv
`timescale 1ns/1ps
module pixwin_seq_bench;
    localparam int COLS  = 16;
    localparam int ROWS  = 8;
    localparam int PIX_W = 8;
    localparam int CW    = 4;
    localparam int RW    = 3;
    localparam int REG_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic [REG_W-1:0] cfg_wdata = '0;
    logic             frame_start = 1'b0;
    logic             dual_mode = 1'b0;
    logic [PIX_W-1:0] bus_a = '0;
    logic [PIX_W-1:0] bus_b = '0;
    logic             scanning;
    logic [CW-1:0]    col_addr;
    logic [RW-1:0]    row_addr;
    logic             col_eos, row_eos, row_end, frame_done;
    logic [PIX_W-1:0] out0_data, out1_data;
    logic             out0_valid, out1_valid;

    int n_vec  = 0;
    int n_bad  = 0;
    int pend [4];

    always #4 clk = ~clk;

    pixwin_seq #(
        .COLS (COLS), .ROWS (ROWS), .PIX_W (PIX_W)
    ) u_pixwin_seq (
        .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
        .cfg_wdata (cfg_wdata), .frame_start (frame_start), .dual_mode (dual_mode),
        .bus_a (bus_a), .bus_b (bus_b), .scanning (scanning),
        .col_addr (col_addr), .row_addr (row_addr), .col_eos (col_eos),
        .row_eos (row_eos), .row_end (row_end), .frame_done (frame_done),
        .out0_data (out0_data), .out0_valid (out0_valid),
        .out1_data (out1_data), .out1_valid (out1_valid)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int last_of(input int first, input int size, input int edge_pos);
        int s;
        int l;
        s = size & ~1;
        if (s < 2) s = 2;
        l = first + s - 2;
        return (l > edge_pos) ? edge_pos : l;
    endfunction

    task automatic write_cfg(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = REG_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        pend[sel] = val;
    endtask

    // One frame: optional write together with the start, optional write plus
    // repeated start at step mid_step.
    task automatic run_frame(input bit dual, input bit wr_start, input int ws_sel, input int ws_val,
                             input int mid_step, input int mid_sel, input int mid_val);
        int cs, rs, cl, rl, step;
        bit mid_done;
        cs = pend[0] & ~1;
        rs = pend[1] & ~1;
        cl = last_of(cs, pend[2], COLS - 2);
        rl = last_of(rs, pend[3], ROWS - 2);
        step = 0;
        mid_done = 1'b0;
        @(negedge clk);
        frame_start = 1'b1;
        dual_mode = dual;
        if (wr_start) begin
            cfg_we = 1'b1; cfg_sel = 2'(ws_sel); cfg_wdata = REG_W'(ws_val);
        end
        @(negedge clk);
        frame_start = 1'b0;
        cfg_we = 1'b0;
        dual_mode = ~dual;
        if (wr_start) pend[ws_sel] = ws_val;
        for (int r = rs; r <= rl; r += 2) begin
            for (int c = cs; c <= cl; c += 2) begin
                for (int ph = 0; ph < 2; ph++) begin
                    bit re, fd;
                    bus_a = PIX_W'(step * 7 + 3);
                    bus_b = PIX_W'(255 - step * 5);
                    #1;
                    re = (c == cl) && (ph == 1);
                    fd = re && (r == rl);
                    if (step == 0) begin
                        check(wr_start ? "R10" : "R2", "first col", int'(col_addr), c);
                        check(wr_start ? "R10" : "R2", "first row", int'(row_addr), r);
                    end else begin
                        check(mid_done ? "R9 R11" : "R3", "col_addr", int'(col_addr), c);
                        check(mid_done ? "R9 R11" : "R3", "row_addr", int'(row_addr), r);
                    end
                    check("R4 R7", "col_eos", int'(col_eos), int'(c == cl));
                    check("R4", "row_eos", int'(row_eos), int'(r == rl));
                    check("R7", "row_end", int'(row_end), int'(re));
                    check("R8", "frame_done", int'(frame_done), int'(fd));
                    if (dual) begin
                        check("R6", "out0_valid", int'(out0_valid), int'(ph == 0));
                        check("R6", "out1_valid", int'(out1_valid), int'(ph == 0));
                        check("R6", "out0_data", int'(out0_data), int'(bus_a));
                        check("R6", "out1_data", int'(out1_data), int'(bus_b));
                    end else begin
                        check("R5", "out0_valid", int'(out0_valid), 1);
                        check("R5", "out1_valid", int'(out1_valid), 0);
                        check("R5", "out0_data", int'(out0_data), (ph == 0) ? int'(bus_a) : int'(bus_b));
                    end
                    if (step == mid_step) begin
                        cfg_we = 1'b1; cfg_sel = 2'(mid_sel); cfg_wdata = REG_W'(mid_val);
                        frame_start = 1'b1;
                        mid_done = 1'b1;
                        pend[mid_sel] = mid_val;
                    end else begin
                        cfg_we = 1'b0;
                        frame_start = 1'b0;
                    end
                    step++;
                    @(negedge clk);
                end
            end
        end
        #1;
        check("R8", "scanning after frame", int'(scanning), 0);
        check("R8", "frame_done after frame", int'(frame_done), 0);
        check("R8", "out0_valid after frame", int'(out0_valid), 0);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        pend[0] = 0; pend[1] = 0; pend[2] = COLS; pend[3] = ROWS;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "scanning", int'(scanning), 0);
        check("R1", "out0_valid", int'(out0_valid), 0);
        check("R1", "out1_valid", int'(out1_valid), 0);
        check("R1", "row_end", int'(row_end), 0);
        check("R1", "frame_done", int'(frame_done), 0);

        // R12: reset defaults give the full array
        run_frame(1'b0, 1'b0, 0, 0, -1, 0, 0);
        run_frame(1'b1, 1'b0, 0, 0, -1, 0, 0);

        // odd starts are forced even (R2)
        write_cfg(0, 5); write_cfg(1, 3); write_cfg(2, 6); write_cfg(3, 4);
        run_frame(1'b0, 1'b0, 0, 0, -1, 0, 0);
        run_frame(1'b1, 1'b0, 0, 0, -1, 0, 0);

        // clamping and odd size (R4)
        write_cfg(0, 12); write_cfg(1, 6); write_cfg(2, 10); write_cfg(3, 9);
        run_frame(1'b1, 1'b0, 0, 0, -1, 0, 0);
        run_frame(1'b0, 1'b0, 0, 0, -1, 0, 0);

        // zero and one-wide sizes collapse to one pair (R4)
        write_cfg(0, 0); write_cfg(1, 0); write_cfg(2, 0); write_cfg(3, 1);
        run_frame(1'b0, 1'b0, 0, 0, -1, 0, 0);

        // mid-frame write plus repeated start (R9, R11)
        write_cfg(0, 2); write_cfg(1, 2); write_cfg(2, 8); write_cfg(3, 4);
        run_frame(1'b0, 1'b0, 0, 0, 3, 0, 10);
        run_frame(1'b0, 1'b0, 0, 0, -1, 0, 0);

        // write in the start cycle (R10): old value now, new value next frame
        run_frame(1'b1, 1'b1, 0, 4, -1, 0, 0);
        run_frame(1'b1, 1'b0, 0, 0, -1, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule